// File: doc/BRIEF.md
# Two-Stage Searchable-Queue Processor

A small in-order processor split into a fetch/decode stage and an execute stage. Fetch reads the instruction word at the program counter, looks up its source registers in the register file, and pushes a decoded template (operation, destination name, two operand values) into a short queue between the stages. Execute takes the oldest template and performs an add, a branch-if-zero, a load or a store. Instruction and data memory sit outside the block as plain arrays with an asynchronous read: the address goes out and the word comes back in the same cycle. Data writes take effect at the next rising clock edge.

Hazards are resolved by searching the queue. Each cycle, fetch compares its source register names against the destinations of every queued template that will write the register file. On a hit it holds the program counter and pushes nothing. A taken branch reloads the program counter from its target operand, empties the queue, and blocks the fetch in that cycle. When nothing blocks fetch, it pushes in the same cycle that execute pops, so both stages advance together.

Top module: `tpipe_core`

## Requirements
- R1: While rst_ni is low and immediately after it is released, imem_addr_o is 0, dmem_we_o is 0 and the queue holds no template.
- R2: The instruction word is 17 bits. Bits [16:15] give the operation (0 add, 1 branch-if-zero, 2 load, 3 store), and bits [14:10], [9:5] and [4:0] are register fields A, B and C. The program counter rises by one only in a cycle where fetch pushes a template.
- R3: Fetch holds imem_addr_o and pushes nothing while a queued add or load targets a register the current instruction reads. The registers read are B and C for add, A and B for branch-if-zero, B for load, and A and B for store.
- R4: When the head template is popped and the fetched instruction has no hazard, fetch pushes in that same cycle. The queue is never pushed while full unless it is also popped.
- R5: Add (A = destination, B and C = sources) writes the 32-bit sum of the source values to register A.
- R6: Load (A = destination, B = address register) drives dmem_addr_o with the value of B and writes dmem_rdata_i into register A.
- R7: Store (A = value register, B = address register) asserts dmem_we_o for one cycle, with dmem_addr_o equal to the value of B and dmem_wdata_o equal to the value of A.
- R8: Branch-if-zero (A = condition register, B = target register) with a nonzero condition only removes its template. No register or memory is written, and fetch continues in order.
- R9: Branch-if-zero with a zero condition loads the program counter with the value of B, empties the queue, and suppresses any fetch push in that cycle. Instructions after the branch never execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| imem_addr_o | output | 32 | Program counter, instruction memory address |
| imem_data_i | input | 17 | Instruction word at imem_addr_o |
| dmem_addr_o | output | 32 | Data memory address for load or store |
| dmem_wdata_o | output | 32 | Store data |
| dmem_we_o | output | 1 | Store strobe |
| dmem_rdata_i | input | 32 | Data memory word at dmem_addr_o |

## Verification
The hardest case to reach is a taken branch whose execute cycle coincides with a fetch that has no hazard and would otherwise push. The branch comes right after a not-taken branch, so the queue is in steady flow, and the two instructions on the wrong path are independent stores whose effects would show up at the data port. A chain of back-to-back load-to-load and add-to-add dependencies exercises the stall. An independent add placed directly after that chain shows fetch and execute advancing in the same cycle, and the bench confirms this from the exact cycle-by-cycle values of imem_addr_o.

// File: rtl/tpipe_pkg.sv
package tpipe_pkg;
  localparam int REG_W   = 5;
  localparam int NREG    = 1 << REG_W;
  localparam int DATA_W  = 32;
  localparam int OP_W    = 2;
  localparam int INSTR_W = OP_W + 3 * REG_W;
  localparam int NFIND   = 2;

  typedef enum logic [OP_W-1:0] {
    OP_ADD   = 2'd0,
    OP_BZ    = 2'd1,
    OP_LOAD  = 2'd2,
    OP_STORE = 2'd3
  } op_e;

  typedef struct packed {
    op_e               op;
    logic [REG_W-1:0]  dst;
    logic [DATA_W-1:0] v1;
    logic [DATA_W-1:0] v2;
  } tmpl_t;

  function automatic logic writes_rf(op_e op);
    return (op == OP_ADD) || (op == OP_LOAD);
  endfunction
endpackage

// File: rtl/tpipe_regfile.sv
module tpipe_regfile
  import tpipe_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_W-1:0]  raddr0_i,
  input  logic [REG_W-1:0]  raddr1_i,
  output logic [DATA_W-1:0] rdata0_o,
  output logic [DATA_W-1:0] rdata1_o,
  input  logic              we_i,
  input  logic [REG_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i
);
  logic [DATA_W-1:0] regs_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (we_i) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  // Read sees the value before this cycle's write; the queue search covers the gap.
  assign rdata0_o = regs_q[raddr0_i];
  assign rdata1_o = regs_q[raddr1_i];
endmodule

// File: rtl/tpipe_squeue.sv
module tpipe_squeue
  import tpipe_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        push_i,
  input  tmpl_t                       push_data_i,
  input  logic                        pop_i,
  input  logic                        clear_i,
  output tmpl_t                       head_o,
  output logic                        head_valid_o,
  output logic                        full_o,
  input  logic [NFIND-1:0][REG_W-1:0] find_name_i,
  output logic [NFIND-1:0]            find_hit_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  tmpl_t             slots_q [DEPTH];
  logic [DEPTH-1:0]  valid_q;
  logic [PTR_W-1:0]  head_q, tail_q;

  function automatic logic [PTR_W-1:0] next_ptr(logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      head_q  <= '0;
      tail_q  <= '0;
    end else if (clear_i) begin
      valid_q <= '0;
      head_q  <= '0;
      tail_q  <= '0;
    end else begin
      if (pop_i) begin
        valid_q[head_q] <= 1'b0;
        head_q          <= next_ptr(head_q);
      end
      if (push_i) begin
        valid_q[tail_q] <= 1'b1;
        tail_q          <= next_ptr(tail_q);
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !clear_i) slots_q[tail_q] <= push_data_i;
  end

  assign head_o       = slots_q[head_q];
  assign head_valid_o = valid_q[head_q];
  assign full_o       = &valid_q;

  // Conservative search: the entry being popped this cycle still counts.
  for (genvar f = 0; f < NFIND; f++) begin : g_find
    logic [DEPTH-1:0] match;
    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      assign match[s] = valid_q[s] && writes_rf(slots_q[s].op) &&
                        (slots_q[s].dst == find_name_i[f]);
    end
    assign find_hit_o[f] = |match;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (!full_o || pop_i)); // R4
  AST_NO_POP_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> head_valid_o); // R4
  AST_CLEAR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (valid_q == '0)); // R9
endmodule

// File: rtl/tpipe_exec.sv
module tpipe_exec
  import tpipe_pkg::*;
(
  input  tmpl_t             head_i,
  input  logic              head_valid_i,
  input  logic [DATA_W-1:0] dmem_rdata_i,
  output logic              pop_o,
  output logic              taken_o,
  output logic [DATA_W-1:0] target_o,
  output logic              rf_we_o,
  output logic [REG_W-1:0]  rf_waddr_o,
  output logic [DATA_W-1:0] rf_wdata_o,
  output logic              dmem_we_o,
  output logic [DATA_W-1:0] dmem_addr_o,
  output logic [DATA_W-1:0] dmem_wdata_o
);
  always_comb begin
    pop_o        = 1'b0;
    taken_o      = 1'b0;
    rf_we_o      = 1'b0;
    rf_wdata_o   = '0;
    dmem_we_o    = 1'b0;
    dmem_addr_o  = '0;
    dmem_wdata_o = '0;
    if (head_valid_i) begin
      unique case (head_i.op)
        OP_ADD: begin
          rf_we_o    = 1'b1;
          rf_wdata_o = head_i.v1 + head_i.v2;
          pop_o      = 1'b1;
        end
        OP_BZ: begin
          if (head_i.v1 == '0) taken_o = 1'b1;
          else                 pop_o   = 1'b1;
        end
        OP_LOAD: begin
          dmem_addr_o = head_i.v1;
          rf_we_o     = 1'b1;
          rf_wdata_o  = dmem_rdata_i;
          pop_o       = 1'b1;
        end
        OP_STORE: begin
          dmem_addr_o  = head_i.v2;
          dmem_wdata_o = head_i.v1;
          dmem_we_o    = 1'b1;
          pop_o        = 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign target_o   = head_i.v2;
  assign rf_waddr_o = head_i.dst;
endmodule

// File: rtl/tpipe_core.sv
module tpipe_core
  import tpipe_pkg::*;
#(
  parameter int QDEPTH = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  output logic [DATA_W-1:0]  imem_addr_o,
  input  logic [INSTR_W-1:0] imem_data_i,
  output logic [DATA_W-1:0]  dmem_addr_o,
  output logic [DATA_W-1:0]  dmem_wdata_o,
  output logic               dmem_we_o,
  input  logic [DATA_W-1:0]  dmem_rdata_i
);
  logic [DATA_W-1:0] pc_q;

  // Decode
  op_e              dec_op;
  logic [REG_W-1:0] fld_a, fld_b, fld_c;
  logic [REG_W-1:0] src0, src1;
  logic             use1;
  assign dec_op = op_e'(imem_data_i[INSTR_W-1 -: OP_W]);
  assign fld_a  = imem_data_i[3*REG_W-1 -: REG_W];
  assign fld_b  = imem_data_i[2*REG_W-1 -: REG_W];
  assign fld_c  = imem_data_i[REG_W-1:0];
  assign src0   = (dec_op == OP_ADD || dec_op == OP_LOAD) ? fld_b : fld_a;
  assign src1   = (dec_op == OP_ADD) ? fld_c : fld_b;
  assign use1   = (dec_op != OP_LOAD);

  logic [DATA_W-1:0] rd0, rd1;
  logic              rf_we;
  logic [REG_W-1:0]  rf_waddr;
  logic [DATA_W-1:0] rf_wdata;

  tpipe_regfile u_rf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .raddr0_i (src0),
    .raddr1_i (src1),
    .rdata0_o (rd0),
    .rdata1_o (rd1),
    .we_i     (rf_we),
    .waddr_i  (rf_waddr),
    .wdata_i  (rf_wdata)
  );

  // Queue between stages
  tmpl_t                       push_tmpl, head;
  logic                        q_push, q_pop, q_full, head_valid, br_taken;
  logic [NFIND-1:0][REG_W-1:0] find_names;
  logic [NFIND-1:0]            find_hit;
  logic                        stall;
  logic [DATA_W-1:0]           br_target;

  assign find_names = {src1, src0};
  assign stall      = find_hit[0] || (use1 && find_hit[1]);
  assign push_tmpl  = '{op: dec_op, dst: fld_a, v1: rd0, v2: rd1};
  assign q_push     = !br_taken && !stall && (!q_full || q_pop);

  tpipe_squeue #(.DEPTH(QDEPTH)) u_q (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_i       (q_push),
    .push_data_i  (push_tmpl),
    .pop_i        (q_pop),
    .clear_i      (br_taken),
    .head_o       (head),
    .head_valid_o (head_valid),
    .full_o       (q_full),
    .find_name_i  (find_names),
    .find_hit_o   (find_hit)
  );

  tpipe_exec u_exec (
    .head_i       (head),
    .head_valid_i (head_valid),
    .dmem_rdata_i (dmem_rdata_i),
    .pop_o        (q_pop),
    .taken_o      (br_taken),
    .target_o     (br_target),
    .rf_we_o      (rf_we),
    .rf_waddr_o   (rf_waddr),
    .rf_wdata_o   (rf_wdata),
    .dmem_we_o    (dmem_we_o),
    .dmem_addr_o  (dmem_addr_o),
    .dmem_wdata_o (dmem_wdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pc_q <= '0;
    else if (br_taken) pc_q <= br_target;
    else if (q_push)   pc_q <= pc_q + 1'b1;
  end

  assign imem_addr_o = pc_q;

  AST_STALL_HOLDS_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall && !br_taken) |=> $stable(imem_addr_o)); // R3
  AST_TAKEN_NO_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_taken |-> !q_push); // R9
  AST_NOT_TAKEN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (head_valid && head.op == OP_BZ && !br_taken) |-> (!rf_we && !dmem_we_o && q_pop)); // R8
  AST_STORE_POPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmem_we_o |-> (q_pop && !rf_we)); // R7
  AST_RESET_IDLE: assert property (@(posedge clk_i)
    !rst_ni |-> (!dmem_we_o && imem_addr_o == '0)); // R1
endmodule

// File: tb/tpipe_core_tb_top.sv
`timescale 1ns/1ps
module tpipe_core_tb_top;
  import tpipe_pkg::*;

  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic [DATA_W-1:0]  imem_addr_o, dmem_addr_o, dmem_wdata_o, dmem_rdata_i;
  logic [INSTR_W-1:0] imem_data_i;
  logic               dmem_we_o;

  logic [INSTR_W-1:0] imem [32];
  logic [DATA_W-1:0]  dmem [256];

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  typedef struct { int addr; int data; string req; } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  tpipe_core dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .imem_addr_o  (imem_addr_o),
    .imem_data_i  (imem_data_i),
    .dmem_addr_o  (dmem_addr_o),
    .dmem_wdata_o (dmem_wdata_o),
    .dmem_we_o    (dmem_we_o),
    .dmem_rdata_i (dmem_rdata_i)
  );

  assign imem_data_i  = imem[imem_addr_o[4:0]];
  assign dmem_rdata_i = dmem[dmem_addr_o[7:0]];

  always @(posedge clk) if (rst_ni && dmem_we_o) dmem[dmem_addr_o[7:0]] <= dmem_wdata_o;

  function automatic logic [INSTR_W-1:0] enc(op_e op, int a, int b, int c);
    return {op, REG_W'(a), REG_W'(b), REG_W'(c)};
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic push_exp(int addr, int data, string req);
    exp_q.push_back('{addr, data, req});
  endtask

  // Monitor: every store strobe is compared against the next expected write
  always @(negedge clk) begin
    if (rst_ni && dmem_we_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected store addr", int'(dmem_addr_o), -1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(int'(dmem_addr_o) == e.addr, {e.req, " store addr"}, int'(dmem_addr_o), e.addr);
        check(int'(dmem_wdata_o) == e.data, {e.req, " store data"}, int'(dmem_wdata_o), e.data);
      end
    end
  end

  task automatic pc_after_edge(int expv, string req);
    @(negedge clk);
    check(int'(imem_addr_o) == expv, req, int'(imem_addr_o), expv);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) imem[i] = enc(OP_BZ, 0, 10, 0);
    for (int i = 0; i < 256; i++) dmem[i] = '0;
    dmem[0] = 1; dmem[1] = 10; dmem[2] = 12; dmem[3] = 19;
    imem[0]  = enc(OP_LOAD, 1, 0, 0);   // r1 = 1
    imem[1]  = enc(OP_LOAD, 2, 1, 0);   // r2 = 10
    imem[2]  = enc(OP_ADD, 3, 2, 2);    // r3 = 20
    imem[3]  = enc(OP_ADD, 4, 3, 1);    // r4 = 21
    imem[4]  = enc(OP_ADD, 6, 1, 1);    // r6 = 2
    imem[5]  = enc(OP_LOAD, 5, 6, 0);   // r5 = 12
    imem[6]  = enc(OP_STORE, 4, 1, 0);  // mem[1] = 21
    imem[7]  = enc(OP_BZ, 1, 5, 0);     // not taken
    imem[8]  = enc(OP_BZ, 0, 5, 0);     // taken to 12
    imem[9]  = enc(OP_STORE, 4, 0, 0);  // wrong path
    imem[10] = enc(OP_STORE, 3, 0, 0);  // wrong path
    imem[12] = enc(OP_STORE, 3, 6, 0);  // mem[2] = 20
    imem[13] = enc(OP_ADD, 7, 4, 3);    // r7 = 41
    imem[14] = enc(OP_STORE, 7, 0, 0);  // mem[0] = 41
    imem[15] = enc(OP_LOAD, 8, 0, 0);   // r8 = 41
    imem[16] = enc(OP_STORE, 8, 3, 0);  // mem[20] = 41
    imem[17] = enc(OP_ADD, 9, 6, 1);    // r9 = 3
    imem[18] = enc(OP_LOAD, 10, 9, 0);  // r10 = 19
    imem[19] = enc(OP_BZ, 0, 10, 0);    // self loop

    push_exp(1, 21, "R7 R5");
    push_exp(2, 20, "R9 R8");
    push_exp(0, 41, "R5 R7");
    push_exp(20, 41, "R6");

    repeat (2) @(negedge clk);
    check(imem_addr_o == 0, "R1 pc in reset", int'(imem_addr_o), 0);
    check(dmem_we_o == 0, "R1 no store in reset", int'(dmem_we_o), 0);
    rst_ni = 1'b1;
    check(imem_addr_o == 0, "R1 pc after release", int'(imem_addr_o), 0);

    pc_after_edge(1, "R2 pc advances on push");
    pc_after_edge(1, "R3 load-use stall");
    pc_after_edge(2, "R2 push after stall");
    pc_after_edge(2, "R3 load-add stall");
    pc_after_edge(3, "R2 push after stall");
    pc_after_edge(3, "R3 add-add stall");
    pc_after_edge(4, "R2 push after stall");
    pc_after_edge(5, "R4 push with pop");
    pc_after_edge(5, "R3 add-load stall");

    repeat (200) @(negedge clk);
    check(imem_addr_o == 19, "R9 parked at loop", int'(imem_addr_o), 19);
    check(exp_q.size() == 0, "R7 all stores seen", exp_q.size(), 0);
    check(dmem[0] == 41, "R5 mem0", int'(dmem[0]), 41);
    check(dmem[1] == 21, "R5 mem1", int'(dmem[1]), 21);
    check(dmem[2] == 20, "R9 mem2", int'(dmem[2]), 20);
    check(dmem[20] == 41, "R6 mem20", int'(dmem[20]), 41);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule